// File: doc/BRIEF.md
# Boot Strap Latch and Remapping Chip-Select Decoder

This block decides how the chip boots and turns bus addresses into device selects. While power-on reset is held low it samples three strap inputs on every clock. Two straps give the width of the boot device. One strap chooses whether the chip boots from the external device on select 0 or from the internal ROM. When power-on reset is released the sampled values are frozen. They stay frozen through system resets and only change at the next power-on reset.

After any reset the block is in standby and drives every select inactive. A rising edge on the wake-up input starts it running. The edge is found after a two-flop synchronizer. Once running, the top nibble of a registered bus address picks one of eight selects. In internal-ROM boot mode the select order is reversed and the high bit of every bus-width field is inverted. As a result the ROM (select 7) answers at address zero after an internal boot, and at the 0x7 region after a normal boot.

Top module: `boot_remap_decoder`

## Requirements
- R1: `boot_width` holds the `strap_width` value sampled at the last clock edge before `por_n` rises. The codes are 00 = 32-bit, 01 = 8-bit, 10 = 16-bit and 11 = undefined, and they are passed through unchanged.
- R2: `boot_internal` is 1 when `strap_src` was low at that same edge (boot from internal ROM). It is 0 when `strap_src` was high (boot from the external device on select 0).
- R3: After `por_n` is high, `boot_width` and `boot_internal` do not change. This holds when the straps change and when `sys_rst_n` is pulsed.
- R4: While either reset is low, and afterwards until a wake-up edge, `running` is 0 and every select is inactive. `running` rises at the third rising clock edge after `wake_in` goes high, and it then stays high until the next reset.
- R5: In normal mode a running block with registered address bits [31:28] = n, where n < 8, activates select n. The address is registered on a clock edge, so the outputs follow one edge after `addr_in` changes.
- R6: In internal-ROM mode, n < 8 activates select 7-n. The ROM select (7) therefore answers at 0x0xxxxxxx in internal mode and at 0x7xxxxxxx in normal mode.
- R7: An address with bit 31 set activates no select and gives `acc_width` = 00.
- R8: Selects 0 to 5 leave on `cs_ext_n[5:0]` as active-low signals. Selects 6 and 7 leave on `cs_int[1:0]` as active-high signals, with bit 1 being select 7. At most one select is active at a time.
- R9: `acc_width` is the field `cfg_width[2k+1:2k]` of the active select k, using the encoding 00 = 32-bit, 01 = 16-bit, 10 = 8-bit. In internal-ROM mode bit 1 of the field is inverted first, so a field of 00 reads as 10 (8-bit). With no select active, `acc_width` is 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low; straps are sampled while it is low |
| sys_rst_n | input | 1 | System reset, active low; does not touch the latched boot state |
| strap_width | input | 2 | Boot-device width strap |
| strap_src | input | 1 | Boot-source strap, high = external device |
| wake_in | input | 1 | Asynchronous wake-up input |
| addr_in | input | 32 | Bus address, registered on each clock |
| cfg_width | input | 16 | Bus-width fields, 2 bits per select |
| boot_width | output | 2 | Latched boot-device width code |
| boot_internal | output | 1 | Latched boot-from-internal-ROM flag |
| running | output | 1 | High once the wake-up edge has been seen |
| cs_ext_n | output | 6 | Active-low selects 0 to 5 |
| cs_int | output | 2 | Active-high internal selects 6 (bit 0) and 7 (bit 1) |
| acc_width | output | 2 | Width code for the active select |

## Verification
The assertions assume `por_n` is low from the first clock. They also assume `wake_in` changes slowly enough for the synchronizer to see each level for at least one clock. The bench holds power-on reset from time zero, drives every input at the falling clock edge, and keeps `wake_in` at each level for several clocks. It lowers `wake_in` before a system reset, so no false wake-up edge appears when the reset is released. The same address vector table is applied once after a normal boot and once after an internal-ROM boot. This lets the reversed map and the width inversion be compared against the same stimulus.

// File: rtl/boot_remap_pkg.sv
package boot_remap_pkg;

  localparam int FIELD_W = 2;

  typedef logic [FIELD_W-1:0] width_t;

  // Select index after the boot-mode reversal.
  function automatic int unsigned map_sel(int unsigned n, logic rev, int unsigned last);
    return rev ? (last - n) : n;
  endfunction

  // Bus-width field after the boot-mode MSB inversion.
  function automatic width_t map_width(width_t f, logic rev);
    return f ^ {rev, {(FIELD_W-1){1'b0}}};
  endfunction

endpackage

// File: rtl/boot_strap_latch.sv
module boot_strap_latch #(
  parameter int STRAP_W = 2
) (
  input  logic               clk,
  input  logic               por_n,
  input  logic [STRAP_W-1:0] strap_width,
  input  logic               strap_src,
  output logic [STRAP_W-1:0] boot_width,
  output logic               boot_internal
);

  // Transparent while power-on reset is low; frozen once it is released.
  always_ff @(posedge clk) begin
    if (!por_n) begin
      boot_width    <= strap_width;
      boot_internal <= ~strap_src;
    end
  end

endmodule

// File: rtl/wake_gate.sv
module wake_gate #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic wake_in,
  output logic wake_rise,
  output logic running
);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   last_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q  <= '0;
      last_q  <= 1'b0;
      running <= 1'b0;
    end else begin
      sync_q  <= {sync_q[SYNC_STAGES-2:0], wake_in};
      last_q  <= sync_q[SYNC_STAGES-1];
      if (wake_rise) running <= 1'b1;
    end
  end

  assign wake_rise = sync_q[SYNC_STAGES-1] & ~last_q;

endmodule

// File: rtl/cs_remap_decode.sv
module cs_remap_decode
  import boot_remap_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int NUM_CS = 8
) (
  input  logic [ADDR_W-1:0]         addr_q,
  input  logic                      rev,
  input  logic                      enable,
  input  logic [NUM_CS*FIELD_W-1:0] cfg_width,
  output logic [NUM_CS-1:0]         sel_vec,
  output width_t                    acc_width
);

  localparam int IDX_W = $clog2(NUM_CS);
  localparam int TOP_W = IDX_W + 1;

  logic [TOP_W-1:0] top;
  logic             in_range;
  logic [IDX_W-1:0] idx;

  assign top      = addr_q[ADDR_W-1 -: TOP_W];
  assign in_range = enable & ~top[TOP_W-1];
  assign idx      = IDX_W'(map_sel(32'(top[IDX_W-1:0]), rev, 32'(NUM_CS-1)));

  for (genvar k = 0; k < NUM_CS; k++) begin : g_sel
    assign sel_vec[k] = in_range && (idx == IDX_W'(k));
  end

  always_comb begin
    acc_width = '0;
    if (in_range) acc_width = map_width(cfg_width[idx*FIELD_W +: FIELD_W], rev);
  end

endmodule

// File: rtl/boot_remap_decoder.sv
module boot_remap_decoder
  import boot_remap_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int NUM_CS  = 8,
  parameter int NUM_EXT = 6,
  parameter int STRAP_W = 2
) (
  input  logic                      clk,
  input  logic                      por_n,
  input  logic                      sys_rst_n,
  input  logic [STRAP_W-1:0]        strap_width,
  input  logic                      strap_src,
  input  logic                      wake_in,
  input  logic [ADDR_W-1:0]         addr_in,
  input  logic [NUM_CS*FIELD_W-1:0] cfg_width,
  output logic [STRAP_W-1:0]        boot_width,
  output logic                      boot_internal,
  output logic                      running,
  output logic [NUM_EXT-1:0]        cs_ext_n,
  output logic [NUM_CS-NUM_EXT-1:0] cs_int,
  output logic [FIELD_W-1:0]        acc_width
);

  logic              rst;
  logic              wake_rise;
  logic [ADDR_W-1:0] addr_q;
  logic [NUM_CS-1:0] sel_vec;

  assign rst = ~por_n | ~sys_rst_n;

  always_ff @(posedge clk) begin
    if (rst) addr_q <= '0;
    else     addr_q <= addr_in;
  end

  boot_strap_latch #(.STRAP_W(STRAP_W)) i_latch (
    .clk          (clk),
    .por_n        (por_n),
    .strap_width  (strap_width),
    .strap_src    (strap_src),
    .boot_width   (boot_width),
    .boot_internal(boot_internal)
  );

  wake_gate #(.SYNC_STAGES(2)) i_wake (
    .clk      (clk),
    .rst      (rst),
    .wake_in  (wake_in),
    .wake_rise(wake_rise),
    .running  (running)
  );

  cs_remap_decode #(.ADDR_W(ADDR_W), .NUM_CS(NUM_CS)) i_dec (
    .addr_q   (addr_q),
    .rev      (boot_internal),
    .enable   (running),
    .cfg_width(cfg_width),
    .sel_vec  (sel_vec),
    .acc_width(acc_width)
  );

  assign cs_ext_n = ~sel_vec[NUM_EXT-1:0];
  assign cs_int   = sel_vec[NUM_CS-1:NUM_EXT];

endmodule

// File: rtl/boot_remap_chk.sv
module boot_remap_chk #(
  parameter int NUM_CS  = 8,
  parameter int NUM_EXT = 6,
  parameter int STRAP_W = 2
) (
  input logic                      clk,
  input logic                      rst,
  input logic                      por_n,
  input logic                      running,
  input logic                      wake_rise,
  input logic                      addr_msb,
  input logic [NUM_EXT-1:0]        cs_ext_n,
  input logic [NUM_CS-NUM_EXT-1:0] cs_int,
  input logic [1:0]                acc_width,
  input logic [STRAP_W-1:0]        boot_width,
  input logic                      boot_internal
);

  logic [NUM_CS-1:0] active;
  assign active = {cs_int, ~cs_ext_n};

  // R8
  one_sel_chk: assert property (@(posedge clk) disable iff (rst) $onehot0(active));

  // R4
  standby_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !running |-> (active == '0));

  // R4
  wake_start_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(running) |-> $past(wake_rise));

  // R4
  run_hold_chk: assert property (@(posedge clk) disable iff (rst)
    running |=> running);

  // R3
  latch_hold_chk: assert property (@(posedge clk) disable iff (!por_n)
    $past(por_n) |-> ($stable(boot_width) && $stable(boot_internal)));

  // R7
  high_addr_chk: assert property (@(posedge clk) disable iff (rst)
    addr_msb |-> (active == '0 && acc_width == 2'b00));

endmodule

bind boot_remap_decoder boot_remap_chk #(
  .NUM_CS(NUM_CS), .NUM_EXT(NUM_EXT), .STRAP_W(STRAP_W)
) i_chk (
  .clk          (clk),
  .rst          (rst),
  .por_n        (por_n),
  .running      (running),
  .wake_rise    (wake_rise),
  .addr_msb     (addr_q[ADDR_W-1]),
  .cs_ext_n     (cs_ext_n),
  .cs_int       (cs_int),
  .acc_width    (acc_width),
  .boot_width   (boot_width),
  .boot_internal(boot_internal)
);

// File: tb/test_boot_remap_decoder.sv
module test_boot_remap_decoder;

  logic        clk = 1'b0;
  logic        por_n = 1'b0;
  logic        sys_rst_n = 1'b0;
  logic [1:0]  strap_width = 2'b10;
  logic        strap_src = 1'b1;
  logic        wake_in = 1'b0;
  logic [31:0] addr_in = '0;
  logic [15:0] cfg_width = 16'hE4E4; // field k = k mod 4
  logic [1:0]  boot_width;
  logic        boot_internal;
  logic        running;
  logic [5:0]  cs_ext_n;
  logic [1:0]  cs_int;
  logic [1:0]  acc_width;

  int nchk = 0;
  int nfail = 0;

  always #10 clk = ~clk; // 50 MHz

  boot_remap_decoder i_boot_remap_decoder (
    .clk(clk), .por_n(por_n), .sys_rst_n(sys_rst_n),
    .strap_width(strap_width), .strap_src(strap_src), .wake_in(wake_in),
    .addr_in(addr_in), .cfg_width(cfg_width),
    .boot_width(boot_width), .boot_internal(boot_internal), .running(running),
    .cs_ext_n(cs_ext_n), .cs_int(cs_int), .acc_width(acc_width)
  );

  localparam logic [31:0] VEC [16] = '{
    32'h3000_0010, 32'h0000_0000, 32'h7000_0004, 32'h1ABC_0000,
    32'h5FFF_FFFF, 32'h2000_8000, 32'h8000_0000, 32'h4123_4567,
    32'h6000_00FC, 32'hFFFF_FFFF, 32'hA5A5_A5A5, 32'h0FFF_FFFF,
    32'hC000_0000, 32'h7FFF_FFFF, 32'h9000_0001, 32'hE000_0002
  };

  task automatic check(string tag, int act, int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Expected active-high select vector, built from the requirement text.
  function automatic logic [7:0] exp_sel(logic [31:0] a, logic internal);
    logic [7:0] v = '0;
    int n = int'(a[31:28]);
    if (n < 8) begin
      if (internal) v[7 - n] = 1'b1;
      else          v[n] = 1'b1;
    end
    return v;
  endfunction

  function automatic logic [1:0] exp_width(logic [7:0] v, logic internal);
    logic [1:0] w = 2'b00;
    for (int k = 0; k < 8; k++) begin
      if (v[k]) begin
        case (k % 4)
          0: w = 2'b00;
          1: w = 2'b01;
          2: w = 2'b10;
          default: w = 2'b11;
        endcase
        if (internal) w[1] = ~w[1];
      end
    end
    return w;
  endfunction

  task automatic apply(logic [31:0] a, logic internal, string tag);
    logic [7:0] e;
    @(negedge clk);
    addr_in = a;
    @(posedge clk);
    @(negedge clk);
    e = exp_sel(a, internal);
    check({tag, " select"}, int'({cs_int, ~cs_ext_n}), int'(e));
    check("R9 width", int'(acc_width), int'(exp_width(e, internal)));
  endtask

  task automatic wake_up();
    @(negedge clk);
    wake_in = 1'b1;
    @(posedge clk); @(negedge clk);
    check("R4 not yet running after 1 edge", int'(running), 0);
    @(posedge clk); @(negedge clk);
    check("R4 not yet running after 2 edges", int'(running), 0);
    @(posedge clk); @(negedge clk);
    check("R4 running after 3 edges", int'(running), 1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    // Reset state (R4)
    repeat (4) @(posedge clk);
    @(negedge clk);
    check("R4 reset running", int'(running), 0);
    check("R4 reset cs_ext_n", int'(cs_ext_n), 'h3F);
    check("R4 reset cs_int", int'(cs_int), 0);
    por_n = 1'b1;
    sys_rst_n = 1'b1;
    @(posedge clk); @(negedge clk);
    strap_width = 2'b01;
    strap_src = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check("R1 normal boot width", int'(boot_width), 2);
    check("R2 external boot flag", int'(boot_internal), 0);
    check("R3 straps changed after release", int'({boot_width, boot_internal}), 'h4);

    // Standby: valid address but no select (R4)
    addr_in = 32'h2000_0000;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check("R4 standby cs_ext_n", int'(cs_ext_n), 'h3F);
    wake_up();

    for (int i = 0; i < 16; i++) apply(VEC[i], 1'b0, "R5");
    apply(32'h7000_0000, 1'b0, "R6 normal ROM");
    check("R6 ROM on cs_int[1] normal", int'(cs_int), 2);
    apply(32'h9000_0000, 1'b0, "R7");
    check("R7 width zero", int'(acc_width), 0);

    // System reset: back to standby, boot state kept (R3, R4)
    @(negedge clk);
    wake_in = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    sys_rst_n = 1'b0;
    @(posedge clk); @(negedge clk);
    sys_rst_n = 1'b1;
    addr_in = 32'h1000_0000;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R4 standby after sys reset", int'(running), 0);
    check("R4 no select after sys reset", int'(cs_ext_n), 'h3F);
    check("R3 boot state after sys reset", int'({boot_width, boot_internal}), 'h4);

    // Power-on reset with internal boot
    por_n = 1'b0;
    strap_width = 2'b01;
    strap_src = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    por_n = 1'b1;
    @(posedge clk); @(negedge clk);
    strap_src = 1'b1;
    strap_width = 2'b11;
    @(posedge clk); @(negedge clk);
    check("R1 internal boot width", int'(boot_width), 1);
    check("R2 internal boot flag", int'(boot_internal), 1);
    wake_up();

    for (int i = 0; i < 16; i++) apply(VEC[i], 1'b1, "R6");
    apply(32'h0000_0000, 1'b1, "R6 internal ROM");
    check("R6 ROM on cs_int[1] internal", int'(cs_int), 2);
    apply(32'h3000_0000, 1'b1, "R8");
    check("R8 cs_ext_n bit 4 low", int'(cs_ext_n), 'h2F);

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

endmodule